// File: doc/BRIEF.md
# Serial Limit-Word Store

This block holds the 8-bit alarm thresholds used by a converter's comparison logic. Every channel owns two words: a lower threshold and an upper threshold. Channel n's lower threshold sits at word address 2n and its upper threshold at address 2n+1. The parameter `NUM_CH` chooses 2 channels (4 words) or 8 channels (16 words).

A host reaches the store through a four-wire serial slave: an active-low select, a serial clock, a data input and a data output with its own output enable. Each select-low period is one frame. The first four bits of a frame are a command code. The code decides what follows:
- a 4-bit word address and one 8-bit word, for a single write;
- a run of 8-bit words with no address, which fill the whole store in order;
- a 4-bit address, after which the block returns the stored word on the data output.

The comparison logic reads any stored word at any time through a combinational parallel port.

The block runs on one system clock. It assumes that the serial pins are already synchronous to that clock, and that each serial level is held for at least two system clocks.

Top module: `limit_serial_store`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every stored word reads 0x00 on the parallel port, and `sdo_en` and `sdo` are 0.
- R2: While `cs_n` is low, `sdi` is taken on each rising `sck`, starting with the first rising edge of the frame. The first four bits form the command code, and the first bit received is its most significant bit, so a code sent in reverse order is a different code.
- R3: Code 1100 is a single write. It is followed by a 4-bit address sent most significant bit first, then 8 data bits sent least significant bit first. The word reaches the store only when `cs_n` rises after the eighth data bit. Before that rise the old word is still visible.
- R4: If `cs_n` rises before all 8 bits of a word have arrived, that partial word is dropped. In a single write the store is left unchanged. In a burst write, the words completed earlier in the frame stay written.
- R5: Code 1101 is a burst write with no address field. The k-th complete word of the frame is written to address k as soon as its last bit arrives, so the order is CH0 lower, CH0 upper, CH1 lower, and so on. Once all 2·NUM_CH words are written, any further bits in the frame are ignored.
- R6: Code 1011 is a serial read. It is followed by a 4-bit address sent most significant bit first. Bit 0 of the addressed word appears on `sdo` on the falling `sck` that ends the last address bit. Bits 1 to 7 follow, one on each later falling edge. `sdo_en` is 1 from that first falling edge until `cs_n` goes high. Whenever `sdo_en` is 0, `sdo` is 0.
- R7: Any other command code makes the block ignore the rest of the frame. The store does not change and `sdo_en` stays 0 until the next frame.
- R8: An address of 2·NUM_CH or more names no word. A single write to such an address is dropped, and reads of it return 0x00, both serially and on the parallel port.
- R9: `rd_data` always shows the stored word at `rd_addr`, with no clock delay.
- R10: The word on the parallel port changes only in the clock after a write to the store.
- R11: `sdo` changes, and `sdo_en` rises, only in response to a falling `sck`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdo_en | output | 1 | Output enable for sdo; 0 means high impedance |
| rd_addr | input | 4 | Parallel read address |
| rd_data | output | 8 | Stored word at rd_addr |

## Verification
The hardest case to reach from the pins is a frame that ends at an awkward point. Examples are a select that rises partway through a word, a burst that carries more words than the store holds, and a single write checked in the gap between its eighth data bit and the select rising.

The stimulus builds every frame bit by bit, so it can stop a frame after any number of bits. It samples the parallel port before and after each select rise, which shows exactly when a word is committed. Reversed command codes and out-of-range addresses are run on the 2-channel build, where the 4-bit address field can name missing words.

// File: rtl/lsr_pkg.sv
// Package: command codes and frame states shared by the serial limit store.
// Assumes a 4-bit command field received most significant bit first.
package lsr_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] CMD_WRITE_ONE = 4'b1100;
    localparam logic [MODE_W-1:0] CMD_WRITE_ALL = 4'b1101;
    localparam logic [MODE_W-1:0] CMD_READ_ONE  = 4'b1011;

    typedef enum logic [2:0] {
        ST_MODE,
        ST_ADDR,
        ST_DATA,
        ST_RDOUT,
        ST_SKIP
    } frame_state_t;
endpackage

// File: rtl/lsr_pin_edges.sv
// Module: detects rising and falling serial clock edges and the select
// rising edge by comparing the pins against their previous-cycle values.
// Assumes the pins are synchronous to clk.
module lsr_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;

    // Hold the previous pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Edge pulses, valid for one clock.
    always_comb begin
        sck_rise = sck & ~sck_q;
        sck_fall = ~sck & sck_q;
        cs_rise  = cs_n & ~cs_q;
    end
endmodule

// File: rtl/lsr_limit_mem.sv
// Module: register file of limit words with one write port and two
// combinational read ports. Addresses with no word read as zero and
// are never written.
module lsr_limit_mem #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // One stored word; loads when the write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                words[g] <= wr_data;
            end
        end
    end

    // Read port muxes; no match yields zero.
    always_comb begin
        ra_data = '0;
        rb_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ra_addr == AW'(i)) ra_data = words[i];
            if (rb_addr == AW'(i)) rb_data = words[i];
        end
    end
endmodule

// File: rtl/lsr_frame_ctrl.sv
// Module: frame sequencer. Decodes the command code, shifts in the
// address (MSB first) and data (LSB first), issues writes, and shifts
// read data out on falling serial clock edges.
// Assumes edge pulses from lsr_pin_edges and a combinational read word.
module lsr_frame_ctrl
    import lsr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sdi,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          cs_rise,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] rd_word_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdo,
    output logic          sdo_en
);
    localparam int CW = $clog2(DW);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    frame_state_t  state;
    logic [CW-1:0] bit_cnt;
    logic [MODE_W-2:0] mode_sr;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_sr;
    logic [AW-1:0] fill_ptr;
    logic [CW:0]   out_idx;
    logic          burst_q;
    logic          read_q;
    logic          pend_q;
    logic          drive_q;
    logic          sdo_q;

    logic [MODE_W-1:0] code_now;
    logic [DW-1:0]     data_next;
    logic              addr_ok;
    logic              burst_done;
    logic              single_commit;

    // Incoming code, shifted data word and address range check.
    always_comb begin
        code_now  = {mode_sr, sdi};
        data_next = {sdi, data_sr[DW-1:1]};
        addr_ok   = (32'(addr_q) < DEPTH);
    end

    // Write request: burst words immediately, single word at select rise.
    always_comb begin
        burst_done    = !cs_n && sck_rise && (state == ST_DATA) && burst_q
                        && (bit_cnt == CW'(DW - 1));
        single_commit = cs_rise && pend_q && addr_ok;
        wr_en         = burst_done || single_commit;
        wr_addr       = burst_done ? fill_ptr : addr_q;
        wr_data       = burst_done ? data_next : data_sr;
        rd_word_addr  = addr_q;
        sdo_en        = drive_q && !cs_n;
        sdo           = sdo_q && sdo_en;
    end

    // Frame sequencer; select high resets the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_MODE;
            bit_cnt  <= '0;
            mode_sr  <= '0;
            addr_q   <= '0;
            data_sr  <= '0;
            fill_ptr <= '0;
            out_idx  <= '0;
            burst_q  <= 1'b0;
            read_q   <= 1'b0;
            pend_q   <= 1'b0;
            drive_q  <= 1'b0;
            sdo_q    <= 1'b0;
        end else if (cs_n) begin
            state   <= ST_MODE;
            bit_cnt <= '0;
            burst_q <= 1'b0;
            read_q  <= 1'b0;
            pend_q  <= 1'b0;
            drive_q <= 1'b0;
            sdo_q   <= 1'b0;
        end else begin
            case (state)
                ST_MODE: if (sck_rise) begin
                    mode_sr <= code_now[MODE_W-2:0];
                    if (bit_cnt == CW'(MODE_W - 1)) begin
                        bit_cnt <= '0;
                        case (code_now)
                            CMD_WRITE_ONE: state <= ST_ADDR;
                            CMD_READ_ONE: begin
                                state  <= ST_ADDR;
                                read_q <= 1'b1;
                            end
                            CMD_WRITE_ALL: begin
                                state    <= ST_DATA;
                                burst_q  <= 1'b1;
                                fill_ptr <= '0;
                            end
                            default: state <= ST_SKIP;
                        endcase
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_ADDR: if (sck_rise) begin
                    addr_q <= {addr_q[AW-2:0], sdi};
                    if (bit_cnt == CW'(AW - 1)) begin
                        bit_cnt <= '0;
                        out_idx <= '0;
                        state   <= read_q ? ST_RDOUT : ST_DATA;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_DATA: if (sck_rise) begin
                    data_sr <= data_next;
                    if (bit_cnt == CW'(DW - 1)) begin
                        bit_cnt <= '0;
                        if (burst_q) begin
                            fill_ptr <= fill_ptr + 1'b1;
                            if (fill_ptr == LAST_ADDR) state <= ST_SKIP;
                        end else begin
                            pend_q <= 1'b1;
                            state  <= ST_SKIP;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_RDOUT: if (sck_fall) begin
                    drive_q <= 1'b1;
                    if (out_idx < (CW+1)'(DW)) begin
                        sdo_q   <= rd_word[out_idx[CW-1:0]];
                        out_idx <= out_idx + 1'b1;
                    end else begin
                        sdo_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/limit_serial_store.sv
// Module: top of the serial limit-word store. Ties pin edge detection,
// the frame sequencer and the limit register file together.
// Assumes serial pins synchronous to clk, each level held >= 2 clocks.
module limit_serial_store #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 2 * NUM_CH;

    logic              sck_rise;
    logic              sck_fall;
    logic              cs_rise;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] ser_addr;
    logic [DATA_W-1:0] ser_word;

    lsr_pin_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    lsr_frame_ctrl #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .sdi          (sdi),
        .sck_rise     (sck_rise),
        .sck_fall     (sck_fall),
        .cs_rise      (cs_rise),
        .rd_word      (ser_word),
        .rd_word_addr (ser_addr),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .sdo          (sdo),
        .sdo_en       (sdo_en)
    );

    lsr_limit_mem #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ra_addr (rd_addr),
        .ra_data (rd_data),
        .rb_addr (ser_addr),
        .rb_data (ser_word)
    );
endmodule

// File: rtl/limit_serial_store_chk.sv
// Module: property checker for limit_serial_store, attached by bind.
// Assumes it sees the top's pins plus the internal write request.
module limit_serial_store_chk #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sck,
    input logic          sdo,
    input logic          sdo_en,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr
);
    logic [1:0] age;

    // Clocks since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    // R10: parallel word holds unless a write happened.
    assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rst_n || age < 2'd2)
        ($stable(rd_addr) && !$past(wr_en)) |-> $stable(rd_data));

    // R8: no write request ever names a missing word.
    assert_write_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n || age < 2'd2)
        wr_en |-> (32'(wr_addr) < DEPTH));

    // R11: output enable rises only after a falling serial clock.
    assert_enable_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd3)
        $rose(sdo_en) |-> ($past(sck, 2) && !$past(sck)));

    // R11: enabled output bit changes only after a falling serial clock.
    assert_shift_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd3)
        (sdo_en && $past(sdo_en) && (sdo != $past(sdo))) |-> ($past(sck, 2) && !$past(sck)));

    // R6: a disabled output is held at zero.
    assert_quiet_output_R6: assert property (@(posedge clk) disable iff (!rst_n || age < 2'd2)
        !sdo_en |-> !sdo);
endmodule

bind limit_serial_store limit_serial_store_chk #(
    .DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck     (sck),
    .sdo     (sdo),
    .sdo_en  (sdo_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
);

// File: tb/limit_serial_store_tb.sv
// Bench: table-driven single writes and reads, then directed frames
// for reset, commit timing, partial words, bursts and bad codes.
module limit_serial_store_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       sdo_en;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    limit_serial_store #(.NUM_CH(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Entries: {address, data sent, expected readback}
    localparam logic [19:0] VEC [6] = '{
        {4'd0, 8'hA5, 8'hA5},
        {4'd1, 8'h3C, 8'h3C},
        {4'd2, 8'h81, 8'h81},
        {4'd3, 8'h7E, 8'h7E},
        {4'd9, 8'hFF, 8'h00},
        {4'd2, 8'h0F, 8'h0F}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (3) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        half();
        sck = 1'b1;
        half();
        sck = 1'b0;
        half();
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        half();
    endtask

    task automatic frame_close();
        cs_n = 1'b1;
        half();
        half();
    endtask

    task automatic send_code(input logic [3:0] c);
        for (int i = 3; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic send_word(input logic [7:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) send_bit(w[i]);
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] v);
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic write_one(input logic [3:0] a, input logic [7:0] w);
        frame_open();
        send_code(4'b1100);
        send_code(a);
        send_word(w, 8);
        frame_close();
    endtask

    task automatic read_one(input logic [3:0] a, output logic [7:0] v, output logic en_ok);
        frame_open();
        send_code(4'b1011);
        send_code(a);
        en_ok = 1'b1;
        v[0] = sdo;
        if (sdo_en !== 1'b1) en_ok = 1'b0;
        for (int i = 1; i < 8; i++) begin
            sck = 1'b1;
            half();
            sck = 1'b0;
            half();
            v[i] = sdo;
            if (sdo_en !== 1'b1) en_ok = 1'b0;
        end
        frame_close();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       en_ok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        half();

        // R1: reset contents and output state.
        for (int a = 0; a < 4; a++) begin
            peek(4'(a), v);
            check("R1 reset word", v, 8'h00);
        end
        check("R1 sdo_en idle", {7'd0, sdo_en}, 8'h00);
        check("R1 sdo idle", {7'd0, sdo}, 8'h00);

        // R3 R6 R8 R9: table of single writes with parallel and serial readback.
        for (int k = 0; k < 6; k++) begin
            write_one(VEC[k][19:16], VEC[k][15:8]);
            peek(VEC[k][19:16], v);
            check("R3/R9 parallel readback", v, VEC[k][7:0]);
            read_one(VEC[k][19:16], v, en_ok);
            check("R6 serial readback", v, VEC[k][7:0]);
            check("R6 sdo_en during readout", {7'd0, en_ok}, 8'h01);
            check("R6 sdo_en after frame", {7'd0, sdo_en}, 8'h00);
        end

        // R3: word is not visible until select rises.
        rd_addr = 4'd1;
        frame_open();
        send_code(4'b1100);
        send_code(4'd1);
        send_word(8'h55, 8);
        half();
        check("R3 before commit", rd_data, 8'h3C);
        frame_close();
        check("R3 after commit", rd_data, 8'h55);

        // R4: truncated single write leaves the word unchanged.
        frame_open();
        send_code(4'b1100);
        send_code(4'd0);
        send_word(8'h00, 5);
        frame_close();
        peek(4'd0, v);
        check("R4 partial single", v, 8'hA5);

        // R5: burst fills all words in order; the extra word is ignored.
        frame_open();
        send_code(4'b1101);
        send_word(8'h11, 8);
        send_word(8'h22, 8);
        send_word(8'h33, 8);
        send_word(8'h44, 8);
        send_word(8'hEE, 8);
        frame_close();
        for (int a = 0; a < 4; a++) begin
            peek(4'(a), v);
            check("R5 burst word", v, 8'(8'h11 * (a + 1)));
        end

        // R4 R5: burst truncated inside its second word.
        frame_open();
        send_code(4'b1101);
        send_word(8'h99, 8);
        send_word(8'h00, 3);
        frame_close();
        peek(4'd0, v);
        check("R4/R5 first word kept", v, 8'h99);
        peek(4'd1, v);
        check("R4 partial burst word dropped", v, 8'h22);

        // R7: unknown code ignores the frame body.
        frame_open();
        send_code(4'b1111);
        send_code(4'b1100);
        send_code(4'd2);
        send_word(8'h00, 8);
        check("R7 no output enable", {7'd0, sdo_en}, 8'h00);
        frame_close();
        peek(4'd2, v);
        check("R7 store unchanged", v, 8'h33);

        // R2: reversed write code (0011) is not a write.
        frame_open();
        send_code(4'b0011);
        send_code(4'd3);
        send_word(8'h00, 8);
        frame_close();
        peek(4'd3, v);
        check("R2 reversed code ignored", v, 8'h44);

        // R8: out-of-range serial read returns zero.
        read_one(4'd12, v, en_ok);
        check("R8 serial read missing word", v, 8'h00);
        peek(4'd12, v);
        check("R8 parallel read missing word", v, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule